// File: doc/BRIEF.md
# Line Buffer Transfer Strobe Counter

This block keeps track of how many data words have moved between a cache SRAM's memory-side line buffer and the memory bus during one bus cycle. At the start of a cycle it is loaded with the kind of cycle: no data, a single word, or a full line. It is also loaded with the line length in use (four or eight words), the sub-line index of the first word, and the counting mode. From then on it counts transfers and presents the buffer word index that the next transfer uses. When the last expected transfer has been seen, it raises a one-clock done flag.

Two counting modes exist. In clocked mode a ready input is sampled on each rising clock edge, and every sampled high value counts as one transfer. In strobed mode a free-running strobe from the memory side is brought into the clock domain through a synchroniser. Every change of its level, rising or falling, counts as one transfer. In both modes an end-of-cycle input may close the cycle early in place of the final transfer. Transfers that arrive after the cycle has completed, or while no cycle is loaded, leave the block untouched.

Top module: `xfer_strobe_counter`

## Requirements
- R1: After reset `busy` and `done` are 0 and `word_idx` is 0.
- R2: A `load` pulse sets the expected count from `load_kind`: 2'b00 gives 0 transfers, 2'b01 gives 1, and 2'b10 or 2'b11 gives a full line of 8 transfers when `line_long`=1 or 4 when `line_long`=0. For a non-zero count, `busy` is 1 from the clock after `load`.
- R3: In clocked mode (`strobed_mode`=0 at load), each rising clock edge with `busy`=1 and `ready`=1 counts one transfer, and `word_idx` moves to the next word from the following cycle unless that transfer was the final one.
- R4: In strobed mode (`strobed_mode`=1 at load), each level change of `strobe`, in either direction, counts one transfer. The count takes effect on the third rising clock edge after the change. `ready` has no effect in strobed mode, and `strobe` has no effect in clocked mode.
- R5: `word_idx` starts at `start_idx` modulo the line length and advances by one modulo the line length (4 or 8) on each non-final transfer. It holds its value when the cycle completes.
- R6: When the final expected transfer is counted, `done` is 1 for exactly one clock, and `busy` is 0 in that same clock. A count of 0 gives that `done` pulse in the clock right after `load`, with `busy` staying 0.
- R7: `eoc`=1 while `busy`=1 completes the cycle at once with a `done` pulse. When a transfer coincides with `eoc`, the result is the same single `done` pulse, and `word_idx` does not advance.
- R8: With `busy`=0, `ready`, strobe edges and `eoc` cause no `done` and leave `word_idx` unchanged.
- R9: A `load` while `busy`=1 abandons the running cycle: `word_idx` restarts at the new `start_idx`, and no `done` is given for the abandoned cycle. A transfer presented in the `load` clock is not counted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| load | input | 1 | Starts a new bus cycle (one-clock pulse) |
| load_kind | input | 2 | Cycle kind: 00 none, 01 single, 1x full line |
| line_long | input | 1 | Line length: 1 for eight words, 0 for four |
| start_idx | input | 3 | Sub-line index of the first word |
| strobed_mode | input | 1 | Counting mode taken at load: 1 strobed, 0 clocked |
| ready | input | 1 | Clocked-mode transfer ready |
| strobe | input | 1 | Strobed-mode transfer strobe, asynchronous |
| eoc | input | 1 | End of cycle, may replace the last transfer |
| word_idx | output | 3 | Buffer word index of the next transfer |
| busy | output | 1 | A cycle is in progress |
| done | output | 1 | One-clock pulse when the cycle completes |

## Verification
The two functions that can fall in one clock are a counted transfer and the end-of-cycle input. The bench provokes this by raising `ready` together with `eoc` partway through a four-word line. The result is judged correct when the scoreboard receives exactly one `done` pulse, with `word_idx` still on the word the transfer was aimed at. A second overlap, a reload presented in the same clock as a ready pulse, is judged by the index restarting at the new start word and by no completion being reported for the abandoned cycle.

// File: rtl/xfer_pkg.sv
// Shared types for the line buffer transfer counter.
// Assumes line lengths are powers of two.
package xfer_pkg;
    typedef enum logic [1:0] {
        KIND_NONE     = 2'b00,
        KIND_SINGLE   = 2'b01,
        KIND_LINE     = 2'b10,
        KIND_LINE_ALT = 2'b11
    } xfer_kind_e;
endpackage

// File: rtl/xfer_strobe_sync.sv
// Brings an asynchronous strobe into the clock domain through SYNC_STAGES
// flip-flops and flags one clock for every level change of the synced copy.
// Assumes the strobe is low while reset is applied.
module xfer_strobe_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe_async,
    output logic strobe_edge
);
    logic [SYNC_STAGES:0] chain;

    genvar g;
    generate
        for (g = 0; g <= SYNC_STAGES; g++) begin : g_stage
            // Shift the strobe one stage further on each clock.
            always_ff @(posedge clk) begin
                if (!rst_n) chain[g] <= 1'b0;
                else if (g == 0) chain[g] <= strobe_async;
                else chain[g] <= chain[(g == 0) ? 0 : g - 1];
            end
        end
    endgenerate

    // Compare the last synced sample with the one before it.
    always_comb strobe_edge = chain[SYNC_STAGES] ^ chain[SYNC_STAGES-1];
endmodule

// File: rtl/xfer_beat_select.sv
// Picks the transfer event for the mode latched at cycle start:
// the ready level in clocked mode, a synced strobe edge in strobed mode.
module xfer_beat_select (
    input  logic mode_strobed,
    input  logic ready,
    input  logic strobe_edge,
    output logic beat
);
    // Steer the active source to the counter.
    always_comb beat = mode_strobed ? strobe_edge : ready;
endmodule

// File: rtl/xfer_count_core.sv
// Holds the remaining transfer count and the word index of one bus cycle.
// Completes on the final transfer or on end-of-cycle and pulses done for
// one clock. Assumes LINE_LONG and LINE_SHORT are powers of two.
module xfer_count_core
    import xfer_pkg::*;
#(
    parameter int LINE_LONG  = 8,
    parameter int LINE_SHORT = 4,
    parameter int IDX_W      = $clog2(LINE_LONG),
    parameter int CNT_W      = $clog2(LINE_LONG + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [1:0]       load_kind,
    input  logic             line_long,
    input  logic [IDX_W-1:0] start_idx,
    input  logic             strobed_mode,
    input  logic             beat,
    input  logic             eoc,
    output logic             mode_q,
    output logic [IDX_W-1:0] idx_q,
    output logic             busy_q,
    output logic             done_q
);
    localparam logic [IDX_W-1:0] MASK_LONG  = IDX_W'(LINE_LONG - 1);
    localparam logic [IDX_W-1:0] MASK_SHORT = IDX_W'(LINE_SHORT - 1);

    logic [CNT_W-1:0] remain_q;
    logic [CNT_W-1:0] load_count;
    logic [IDX_W-1:0] mask_q;
    logic [IDX_W-1:0] load_mask;
    logic             finish;

    // Translate the cycle kind into an expected transfer count.
    always_comb begin
        load_mask = line_long ? MASK_LONG : MASK_SHORT;
        case (xfer_kind_e'(load_kind))
            KIND_NONE:   load_count = '0;
            KIND_SINGLE: load_count = CNT_W'(1);
            default:     load_count = line_long ? CNT_W'(LINE_LONG) : CNT_W'(LINE_SHORT);
        endcase
    end

    // The cycle ends on end-of-cycle or on the final counted transfer.
    always_comb finish = busy_q && (eoc || (beat && remain_q == CNT_W'(1)));

    // Cycle state: load, count, complete.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q   <= 1'b0;
            idx_q    <= '0;
            mask_q   <= '0;
            remain_q <= '0;
            busy_q   <= 1'b0;
            done_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (load) begin
                mode_q   <= strobed_mode;
                mask_q   <= load_mask;
                idx_q    <= start_idx & load_mask;
                remain_q <= load_count;
                busy_q   <= (load_count != '0);
                done_q   <= (load_count == '0);
            end else if (finish) begin
                busy_q   <= 1'b0;
                done_q   <= 1'b1;
                remain_q <= '0;
            end else if (busy_q && beat) begin
                remain_q <= remain_q - CNT_W'(1);
                idx_q    <= (idx_q + IDX_W'(1)) & mask_q;
            end
        end
    end
endmodule

// File: rtl/xfer_strobe_counter.sv
// Top of the line buffer transfer counter: strobe synchroniser, mode
// select and count core. Assumes strobed_mode is steady while loading.
module xfer_strobe_counter #(
    parameter int LINE_LONG   = 8,
    parameter int LINE_SHORT  = 4,
    parameter int SYNC_STAGES = 2,
    parameter int IDX_W       = $clog2(LINE_LONG)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [1:0]       load_kind,
    input  logic             line_long,
    input  logic [IDX_W-1:0] start_idx,
    input  logic             strobed_mode,
    input  logic             ready,
    input  logic             strobe,
    input  logic             eoc,
    output logic [IDX_W-1:0] word_idx,
    output logic             busy,
    output logic             done
);
    logic strobe_edge;
    logic beat;
    logic mode_q;

    xfer_strobe_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .strobe_async(strobe), .strobe_edge(strobe_edge)
    );

    xfer_beat_select u_sel (
        .mode_strobed(mode_q), .ready(ready), .strobe_edge(strobe_edge), .beat(beat)
    );

    xfer_count_core #(
        .LINE_LONG(LINE_LONG), .LINE_SHORT(LINE_SHORT), .IDX_W(IDX_W)
    ) u_core (
        .clk(clk), .rst_n(rst_n), .load(load), .load_kind(load_kind),
        .line_long(line_long), .start_idx(start_idx), .strobed_mode(strobed_mode),
        .beat(beat), .eoc(eoc), .mode_q(mode_q), .idx_q(word_idx),
        .busy_q(busy), .done_q(done)
    );
endmodule

// File: rtl/xfer_strobe_counter_chk.sv
// Port-level properties of the transfer counter, bound to the top module.
module xfer_strobe_counter_chk #(
    parameter int IDX_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             load,
    input logic [1:0]       load_kind,
    input logic             strobed_mode,
    input logic             ready,
    input logic             eoc,
    input logic [IDX_W-1:0] word_idx,
    input logic             busy,
    input logic             done
);
    // R6: completion is never reported while a cycle still runs.
    a_r6_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R7: end-of-cycle during a running cycle ends it next clock.
    a_r7_eoc_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && eoc && !load) |=> (done && !busy));

    // R8: nothing moves while idle without a load.
    a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !load) |=> (!done && $stable(word_idx)));

    // R9: a non-empty load always starts a running cycle.
    a_r9_load_starts: assert property (@(posedge clk) disable iff (!rst_n)
        (load && load_kind != 2'b00) |=> (busy && !done));

    // R3: a clocked-mode ready either advances the index or ends the cycle.
    a_r3_clocked_step: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !strobed_mode && ready && !eoc && !load)
        |=> (done || word_idx != $past(word_idx)));
endmodule

bind xfer_strobe_counter xfer_strobe_counter_chk #(.IDX_W(IDX_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .load(load), .load_kind(load_kind),
    .strobed_mode(strobed_mode), .ready(ready), .eoc(eoc),
    .word_idx(word_idx), .busy(busy), .done(done)
);

// File: tb/xfer_strobe_counter_test.sv
`timescale 1ns/1ps
module xfer_strobe_counter_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       load = 1'b0;
    logic [1:0] load_kind = 2'b00;
    logic       line_long = 1'b0;
    logic [2:0] start_idx = 3'd0;
    logic       strobed_mode = 1'b0;
    logic       ready = 1'b0;
    logic       strobe = 1'b0;
    logic       eoc = 1'b0;
    logic [2:0] word_idx;
    logic       busy;
    logic       done;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 1'b0;
    logic [2:0] exp_q[$];
    string      tag_q[$];

    xfer_strobe_counter uut (
        .clk(clk), .rst_n(rst_n), .load(load), .load_kind(load_kind),
        .line_long(line_long), .start_idx(start_idx), .strobed_mode(strobed_mode),
        .ready(ready), .strobe(strobe), .eoc(eoc),
        .word_idx(word_idx), .busy(busy), .done(done)
    );

    always #4 clk = ~clk;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Driver side of the scoreboard: expect one completion at index idx.
    task automatic expect_done(input logic [2:0] idx, input string tag);
        exp_q.push_back(idx);
        tag_q.push_back(tag);
    endtask

    // Monitor: every done pulse is matched against the oldest expectation.
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R8 unexpected done", 1, 0);
            end else begin
                logic [2:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(word_idx == e, t, word_idx, e);
            end
        end
    end

    task automatic do_load(input logic [1:0] k, input logic lng, input logic [2:0] s, input logic sm);
        load = 1'b1; load_kind = k; line_long = lng; start_idx = s; strobed_mode = sm;
        @(negedge clk);
        load = 1'b0;
    endtask

    task automatic beats(input int n);
        for (int i = 0; i < n; i++) begin
            ready = 1'b1;
            @(negedge clk);
        end
        ready = 1'b0;
    endtask

    task automatic end_eoc(input logic with_beat);
        eoc = 1'b1; ready = with_beat;
        @(negedge clk);
        eoc = 1'b0; ready = 1'b0;
    endtask

    task automatic toggle_strobe();
        strobe = ~strobe;
        repeat (2) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        #800000;
        check(1'b0, "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state.
        check(busy == 1'b0 && done == 1'b0, "R1 reset flags", {busy, done}, 0);
        check(word_idx == 3'd0, "R1 reset index", word_idx, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 R3 R5 R6: four-word line from index 2 wraps to 1.
        do_load(2'b10, 1'b0, 3'd2, 1'b0);
        check(busy == 1'b1, "R2 busy after load", busy, 1);
        check(word_idx == 3'd2, "R5 start index", word_idx, 2);
        beats(1);
        check(word_idx == 3'd3, "R3 index after one ready", word_idx, 3);
        beats(1);
        check(word_idx == 3'd0, "R5 wrap at four", word_idx, 0);
        expect_done(3'd1, "R6 four-word line final index");
        beats(2);
        check(busy == 1'b0, "R6 busy drops with done", busy, 0);
        @(negedge clk);
        check(done == 1'b0, "R6 done one clock", done, 0);

        // R8: surplus ready and idle eoc have no effect.
        beats(3);
        end_eoc(1'b0);
        check(busy == 1'b0 && word_idx == 3'd1, "R8 idle index held", word_idx, 1);

        // R2 R5: eight-word line from index 5, wraps modulo eight.
        do_load(2'b11, 1'b1, 3'd5, 1'b0);
        beats(7);
        check(busy == 1'b1, "R2 eight-word line still busy after 7", busy, 1);
        expect_done(3'd4, "R2 eight-word line final index");
        beats(1);

        // R2: single transfer, start index masked to four-word line.
        do_load(2'b01, 1'b0, 3'd7, 1'b0);
        check(word_idx == 3'd3, "R5 start masked", word_idx, 3);
        expect_done(3'd3, "R2 single transfer");
        beats(1);

        // R6: zero-count cycle completes right after load.
        expect_done(3'd6, "R6 zero count done");
        do_load(2'b00, 1'b1, 3'd6, 1'b0);
        check(busy == 1'b0, "R6 zero count not busy", busy, 0);
        @(negedge clk);

        // R7: early end-of-cycle after three transfers.
        do_load(2'b10, 1'b1, 3'd0, 1'b0);
        beats(3);
        expect_done(3'd3, "R7 early eoc index");
        end_eoc(1'b0);

        // R7: eoc together with a transfer gives one done, no advance.
        do_load(2'b10, 1'b0, 3'd1, 1'b0);
        beats(1);
        expect_done(3'd2, "R7 eoc with transfer");
        end_eoc(1'b1);
        @(negedge clk);

        // R4: strobed mode ignores ready, counts both strobe edges.
        do_load(2'b10, 1'b0, 3'd0, 1'b1);
        beats(2);
        check(word_idx == 3'd0, "R4 ready ignored in strobed mode", word_idx, 0);
        toggle_strobe();
        @(negedge clk);
        check(word_idx == 3'd1, "R4 rising strobe counted", word_idx, 1);
        toggle_strobe();
        @(negedge clk);
        check(word_idx == 3'd2, "R4 falling strobe counted", word_idx, 2);
        toggle_strobe();
        expect_done(3'd3, "R4 strobed line final index");
        toggle_strobe();
        repeat (3) @(negedge clk);
        check(busy == 1'b0, "R4 strobed line complete", busy, 0);

        // R4: strobe ignored in clocked mode.
        do_load(2'b10, 1'b0, 3'd1, 1'b0);
        toggle_strobe();
        toggle_strobe();
        repeat (3) @(negedge clk);
        check(word_idx == 3'd1 && busy == 1'b1, "R4 strobe ignored in clocked mode", word_idx, 1);
        expect_done(3'd1, "R4 clocked cycle closed by eoc");
        end_eoc(1'b0);

        // R9: reload while busy restarts, ready in load clock not counted.
        do_load(2'b10, 1'b0, 3'd0, 1'b0);
        beats(2);
        ready = 1'b1;
        do_load(2'b10, 1'b0, 3'd2, 1'b0);
        ready = 1'b0;
        check(word_idx == 3'd2 && busy == 1'b1, "R9 restart index", word_idx, 2);
        expect_done(3'd1, "R9 restarted cycle full count");
        beats(4);

        repeat (4) @(negedge clk);
        check(exp_q.size() == 0, "R6 all completions seen", exp_q.size(), 0);
        finish_run();
    end
endmodule